// File: doc/BRIEF.md
# Conditional Branch Decision Unit

This unit settles the outcome of the conditional-branch class of a 16-bit processor. Each issued instruction brings its opcode, two register operands, the value of one selected status flag, the branch target and the current program counter. One clock later the unit returns the next program counter, a taken indication, an optional register write-back carrying a decremented value, and its own C, Z and N flags. The flags stay in the unit between instructions.

The two most significant opcode bits give the instruction class. Only the branch class (binary 10) with opcode bits 5..3 at zero is acted on. Every other instruction falls through to PC + 2, because each instruction is two words long: an opcode word and an address word. The flag-test branches take the branch when the flag is clear (0x80) or when it is set (0x81). Two opcodes combine a zero test with a decrement that is written back only when the branch is not taken. The compare branches subtract the second operand from the first and update the flags as they decide.

Sequencing uses a two-state machine. `ST_IDLE` means no result is presented. `ST_RESULT` means the output registers hold the result of the instruction issued in the previous cycle. The transition *issue* (in_valid high) leads to `ST_RESULT` from either state. The transition *drain* (in_valid low) leads back to `ST_IDLE`.

Top module: `branch_decide`

## Requirements
- R1: An issued opcode whose bits 7..6 are not binary 10 gives taken = 0, next PC = PC + 2 and no register write, and leaves C, Z and N unchanged.
- R2: Opcode 0x80 is taken when the selected flag is 0, and opcode 0x81 is taken when it is 1. Neither changes C, Z or N.
- R3: Opcode 0x82 is taken when the first operand is zero. Otherwise it is not taken and asserts the register write with the first operand minus 1.
- R4: Opcode 0x83 is taken when the first operand is nonzero. Otherwise it is not taken and asserts the register write with 0xFFFF.
- R5: Opcodes 0x84, 0x85, 0x86 and 0x87 are taken when the first operand is, respectively, equal to, unequal to, unsigned greater than, or unsigned greater than or equal to the second operand.
- R6: Opcodes 0x84 to 0x87 set Z when the operands are equal, set N to bit 15 of (first − second), and set C when no borrow occurs (first ≥ second, unsigned).
- R7: Opcodes 0x82 and 0x83 set the flags from (first − 1) on both the taken and the untaken path: Z when the result is zero, N from result bit 15, and C when the first operand is nonzero.
- R8: Next PC equals the target when the branch is taken, and PC + 2 (modulo 2^16) otherwise.
- R9: Opcodes 0x88 to 0xBF are not taken, write no register and leave the flags unchanged.
- R10: Results appear in the cycle after an issue. In a cycle after no issue, out_valid, taken and the register write are low, and next PC and the flags hold their values.
- R11: After reset, out_valid, taken, the register write, next PC and all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | An instruction is issued this cycle |
| opcode_i | input | 8 | Instruction opcode |
| rd_val_i | input | 16 | First operand (decremented register or left compare operand) |
| rs2_val_i | input | 16 | Second compare operand |
| flag_sel_i | input | 1 | Value of the flag that the flag-test branches examine |
| target_i | input | 16 | Branch target address |
| pc_i | input | 16 | Address of the current instruction |
| out_valid_o | output | 1 | Result registers hold a fresh result |
| take_o | output | 1 | Branch taken |
| next_pc_o | output | 16 | Next program counter |
| rd_we_o | output | 1 | Write the decremented value back to the register |
| rd_wdata_o | output | 16 | Decremented value |
| flag_c_o | output | 1 | Carry (no borrow) flag |
| flag_z_o | output | 1 | Zero flag |
| flag_n_o | output | 1 | Negative flag |

## Verification
The assertions assume that every input is a known value at each rising edge while reset is released. They also assume that an issued instruction is presented for exactly the cycle it is sampled, with operand and target values already stable. The bench drives every input at the falling edge, holds the values through the next rising edge, and mixes idle cycles in at random so that the hold behaviour is exercised. Random opcodes are drawn half from the eight branch opcodes and half from the full byte range, so the reserved branch-class opcodes and the other classes are covered as well.

// File: rtl/branch_decide_pkg.sv
package branch_decide_pkg;

    // Instruction class in the two top opcode bits
    typedef enum logic [1:0] {
        CLS_XFER   = 2'b00,
        CLS_ALU    = 2'b01,
        CLS_BRANCH = 2'b10,
        CLS_CTRL   = 2'b11
    } instr_class_e;

    // Branch kind in the three low opcode bits
    typedef enum logic [2:0] {
        BR_FLAG_CLR = 3'd0,
        BR_FLAG_SET = 3'd1,
        BR_ZERO_DEC = 3'd2,
        BR_NZ_DEC   = 3'd3,
        BR_EQ       = 3'd4,
        BR_NE       = 3'd5,
        BR_GT       = 3'd6,
        BR_GE       = 3'd7
    } branch_kind_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } seq_state_e;

endpackage

// File: rtl/bd_class_decode.sv
module bd_class_decode
    import branch_decide_pkg::*;
#(
    parameter int OPW = 8
) (
    input  logic [OPW-1:0] opcode_i,
    output logic           is_branch_o,
    output branch_kind_e   kind_o
);
    instr_class_e cls;

    always_comb begin
        cls         = instr_class_e'(opcode_i[OPW-1 -: 2]);
        // Branch class with the reserved middle bits clear
        is_branch_o = (cls == CLS_BRANCH) && (opcode_i[OPW-3:3] == '0);
        kind_o      = branch_kind_e'(opcode_i[2:0]);
    end
endmodule

// File: rtl/bd_subtract.sv
module bd_subtract #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic [DW-1:0] diff_o,
    output logic          no_borrow_o,
    output logic          zero_o,
    output logic          neg_o
);
    logic borrow;

    always_comb begin
        {borrow, diff_o} = {1'b0, a_i} - {1'b0, b_i};
        no_borrow_o      = ~borrow;
        zero_o           = (diff_o == '0);
        neg_o            = diff_o[DW-1];
    end
endmodule

// File: rtl/bd_cond_select.sv
module bd_cond_select
    import branch_decide_pkg::*;
(
    input  logic         is_branch_i,
    input  branch_kind_e kind_i,
    input  logic         flag_sel_i,
    input  logic         no_borrow_i,
    input  logic         zero_i,
    output logic         take_o,
    output logic         dec_write_o,
    output logic         flag_update_o
);
    // For the decrement kinds the subtrahend is 1, so no borrow means operand nonzero
    always_comb begin
        take_o        = 1'b0;
        dec_write_o   = 1'b0;
        flag_update_o = 1'b0;
        if (is_branch_i) begin
            unique case (kind_i)
                BR_FLAG_CLR: take_o = ~flag_sel_i;
                BR_FLAG_SET: take_o = flag_sel_i;
                BR_ZERO_DEC: begin
                    take_o        = ~no_borrow_i;
                    dec_write_o   = no_borrow_i;
                    flag_update_o = 1'b1;
                end
                BR_NZ_DEC: begin
                    take_o        = no_borrow_i;
                    dec_write_o   = ~no_borrow_i;
                    flag_update_o = 1'b1;
                end
                BR_EQ: begin
                    take_o        = zero_i;
                    flag_update_o = 1'b1;
                end
                BR_NE: begin
                    take_o        = ~zero_i;
                    flag_update_o = 1'b1;
                end
                BR_GT: begin
                    take_o        = no_borrow_i & ~zero_i;
                    flag_update_o = 1'b1;
                end
                BR_GE: begin
                    take_o        = no_borrow_i;
                    flag_update_o = 1'b1;
                end
                default: take_o = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/branch_decide.sv
module branch_decide
    import branch_decide_pkg::*;
#(
    parameter int DW          = 16,
    parameter int AW          = 16,
    parameter int OPW         = 8,
    parameter int INSTR_WORDS = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid_i,
    input  logic [OPW-1:0] opcode_i,
    input  logic [DW-1:0]  rd_val_i,
    input  logic [DW-1:0]  rs2_val_i,
    input  logic           flag_sel_i,
    input  logic [AW-1:0]  target_i,
    input  logic [AW-1:0]  pc_i,
    output logic           out_valid_o,
    output logic           take_o,
    output logic [AW-1:0]  next_pc_o,
    output logic           rd_we_o,
    output logic [DW-1:0]  rd_wdata_o,
    output logic           flag_c_o,
    output logic           flag_z_o,
    output logic           flag_n_o
);
    localparam logic [AW-1:0] PC_STEP = AW'(INSTR_WORDS);

    seq_state_e   state_q, state_d;
    logic         is_branch;
    branch_kind_e kind;
    logic [DW-1:0] subtrahend, diff;
    logic         no_borrow, zero, neg;
    logic         take_d, dec_write, flag_update;
    logic [AW-1:0] next_pc_d;

    bd_class_decode #(.OPW(OPW)) u_decode (
        .opcode_i    (opcode_i),
        .is_branch_o (is_branch),
        .kind_o      (kind)
    );

    // One subtractor serves both the decrement and the compare kinds
    always_comb begin
        if (kind == BR_ZERO_DEC || kind == BR_NZ_DEC)
            subtrahend = DW'(1);
        else
            subtrahend = rs2_val_i;
    end

    bd_subtract #(.DW(DW)) u_sub (
        .a_i         (rd_val_i),
        .b_i         (subtrahend),
        .diff_o      (diff),
        .no_borrow_o (no_borrow),
        .zero_o      (zero),
        .neg_o       (neg)
    );

    bd_cond_select u_select (
        .is_branch_i   (is_branch),
        .kind_i        (kind),
        .flag_sel_i    (flag_sel_i),
        .no_borrow_i   (no_borrow),
        .zero_i        (zero),
        .take_o        (take_d),
        .dec_write_o   (dec_write),
        .flag_update_o (flag_update)
    );

    always_comb next_pc_d = take_d ? target_i : (pc_i + PC_STEP);

    // Next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = in_valid_i ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = in_valid_i ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign out_valid_o = (state_q == ST_RESULT);

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_o     <= 1'b0;
            next_pc_o  <= '0;
            rd_we_o    <= 1'b0;
            rd_wdata_o <= '0;
            flag_c_o   <= 1'b0;
            flag_z_o   <= 1'b0;
            flag_n_o   <= 1'b0;
        end else if (in_valid_i) begin
            take_o     <= take_d;
            next_pc_o  <= next_pc_d;
            rd_we_o    <= dec_write;
            rd_wdata_o <= diff;
            if (flag_update) begin
                flag_c_o <= no_borrow;
                flag_z_o <= zero;
                flag_n_o <= neg;
            end
        end else begin
            take_o  <= 1'b0;
            rd_we_o <= 1'b0;
        end
    end

    // Checks on the sequencing and results
    assert_issue_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> out_valid_o);

    assert_quiet_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> (!out_valid_o && !take_o && !rd_we_o && $stable(next_pc_o)
                         && $stable({flag_c_o, flag_z_o, flag_n_o})));

    assert_write_excludes_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we_o |-> !take_o);

    assert_dec_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> (!rd_we_o || rd_wdata_o == $past(rd_val_i) - DW'(1)));

    assert_pc_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> (take_o ? (next_pc_o == $past(target_i))
                               : (next_pc_o == $past(pc_i) + PC_STEP)));

    assert_other_class_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && opcode_i[OPW-1 -: 2] != 2'b10) |=>
            (!take_o && !rd_we_o && $stable({flag_c_o, flag_z_o, flag_n_o})));

    assert_flag_test_keeps_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && opcode_i[OPW-1:1] == '1 << (OPW-1) >> 1) |=>
            $stable({flag_c_o, flag_z_o, flag_n_o}));

    assert_cmp_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && opcode_i[OPW-1:2] == 6'b100001) |=>
            (flag_z_o == ($past(rd_val_i) == $past(rs2_val_i))));
endmodule

// File: tb/branch_decide_test.sv
module branch_decide_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [15:0] rd_val = '0, rs2_val = '0, target = '0, pc = '0;
    logic        flag_sel = 1'b0;
    logic        out_valid, take, rd_we, fc, fz, fn;
    logic [15:0] next_pc, rd_wdata;

    int checks = 0;
    int fails = 0;
    logic ec = 1'b0, ez = 1'b0, en = 1'b0;
    logic [15:0] last_npc = '0;

    always #5 clk = ~clk;

    branch_decide uut (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .opcode_i(opcode),
        .rd_val_i(rd_val), .rs2_val_i(rs2_val), .flag_sel_i(flag_sel),
        .target_i(target), .pc_i(pc), .out_valid_o(out_valid), .take_o(take),
        .next_pc_o(next_pc), .rd_we_o(rd_we), .rd_wdata_o(rd_wdata),
        .flag_c_o(fc), .flag_z_o(fz), .flag_n_o(fn)
    );

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic string take_tag(input logic [7:0] op);
        if (op[7:6] != 2'b10) return "R1 taken";
        if (op[5:3] != 3'b000) return "R9 taken";
        case (op[2:0])
            3'd0, 3'd1: return "R2 taken";
            3'd2:       return "R3 taken";
            3'd3:       return "R4 taken";
            default:    return "R5 taken";
        endcase
    endfunction

    // Issue one instruction and check the result one cycle later
    task automatic issue(input logic [7:0] op, input logic [15:0] a, input logic [15:0] b,
                         input logic f, input logic [15:0] tgt, input logic [15:0] p);
        logic        x_take = 1'b0, x_we = 1'b0, upd = 1'b0, isdec = 1'b0;
        logic [15:0] sub = b;
        logic [16:0] r;
        logic [15:0] x_npc;
        @(negedge clk);
        in_valid = 1'b1; opcode = op; rd_val = a; rs2_val = b;
        flag_sel = f; target = tgt; pc = p;
        if (op[7:6] == 2'b10 && op[5:3] == 3'b000) begin
            case (op[2:0])
                3'd0: x_take = (f == 1'b0);
                3'd1: x_take = (f == 1'b1);
                3'd2: begin x_take = (a == 0); x_we = (a != 0); upd = 1; isdec = 1; end
                3'd3: begin x_take = (a != 0); x_we = (a == 0); upd = 1; isdec = 1; end
                3'd4: begin x_take = (a == b); upd = 1; end
                3'd5: begin x_take = (a != b); upd = 1; end
                3'd6: begin x_take = (a > b);  upd = 1; end
                default: begin x_take = (a >= b); upd = 1; end
            endcase
        end
        if (isdec) sub = 16'd1;
        r = {1'b0, a} - {1'b0, sub};
        x_npc = x_take ? tgt : p + 16'd2;
        if (upd) begin
            ez = (r[15:0] == 16'd0);
            en = r[15];
            ec = (a >= sub);
        end
        @(negedge clk);
        check(out_valid == 1'b1, "R10 out_valid", {31'd0, out_valid}, 32'd1);
        check(take == x_take, take_tag(op), {31'd0, take}, {31'd0, x_take});
        check(next_pc == x_npc, "R8 next_pc", {16'd0, next_pc}, {16'd0, x_npc});
        check(rd_we == x_we, isdec ? "R3/R4 rd_we" : "R9 rd_we", {31'd0, rd_we}, {31'd0, x_we});
        if (x_we)
            check(rd_wdata == a - 16'd1, op[0] ? "R4 rd_wdata" : "R3 rd_wdata",
                  {16'd0, rd_wdata}, {16'd0, a - 16'd1});
        check({fc, fz, fn} == {ec, ez, en}, isdec ? "R7 flags" : (upd ? "R6 flags" : "R2 flags"),
              {29'd0, fc, fz, fn}, {29'd0, ec, ez, en});
        last_npc = x_npc;
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        in_valid = 1'b0;
        opcode = 8'(($urandom));
        rd_val = 16'($urandom);
        @(negedge clk);
        check({out_valid, take, rd_we} == 3'b000, "R10 idle outputs",
              {29'd0, out_valid, take, rd_we}, 32'd0);
        check(next_pc == last_npc && {fc, fz, fn} == {ec, ez, en}, "R10 hold",
              {13'd0, next_pc, fc, fz, fn}, {13'd0, last_npc, ec, ez, en});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R11 reset state
        check({out_valid, take, rd_we, fc, fz, fn} == 6'd0, "R11 reset outputs",
              {26'd0, out_valid, take, rd_we, fc, fz, fn}, 32'd0);
        check(next_pc == 16'd0, "R11 reset next_pc", {16'd0, next_pc}, 32'd0);
        rst_n = 1'b1;

        // Directed corner cases
        issue(8'h80, 16'h0001, 16'h0002, 1'b0, 16'h1234, 16'h0100);  // R2 flag clear taken
        issue(8'h80, 16'h0001, 16'h0002, 1'b1, 16'h1234, 16'h0100);
        issue(8'h81, 16'h0000, 16'h0000, 1'b1, 16'h2222, 16'h0200);
        issue(8'h81, 16'h0000, 16'h0000, 1'b0, 16'h2222, 16'h0200);
        issue(8'h82, 16'h0000, 16'h0000, 1'b0, 16'h3000, 16'h0300);  // R3 zero taken
        issue(8'h82, 16'h0005, 16'h0000, 1'b0, 16'h3000, 16'h0300);  // R3 decrement
        issue(8'h82, 16'h0001, 16'h0000, 1'b0, 16'h3000, 16'h0300);  // R7 result zero
        issue(8'h83, 16'h0000, 16'h0000, 1'b0, 16'h4000, 16'h0400);  // R4 wrap to FFFF
        issue(8'h83, 16'h8000, 16'h0000, 1'b0, 16'h4000, 16'h0400);
        issue(8'h84, 16'hABCD, 16'hABCD, 1'b0, 16'h5000, 16'h0500);  // R5/R6 equal
        issue(8'h85, 16'hABCD, 16'hABCD, 1'b0, 16'h5000, 16'h0500);
        issue(8'h86, 16'h8000, 16'h7FFF, 1'b0, 16'h6000, 16'h0600);  // unsigned gt
        issue(8'h86, 16'h0003, 16'h0003, 1'b0, 16'h6000, 16'h0600);
        issue(8'h86, 16'h0001, 16'hFFFF, 1'b0, 16'h6000, 16'h0600);
        issue(8'h87, 16'h0007, 16'h0007, 1'b0, 16'h7000, 16'h0700);
        issue(8'h87, 16'h0006, 16'h0007, 1'b0, 16'h7000, 16'h0700);
        issue(8'h88, 16'h0000, 16'h0001, 1'b1, 16'h7777, 16'h0800);  // R9 reserved
        issue(8'hBF, 16'h0000, 16'h0000, 1'b0, 16'h7777, 16'h0800);
        issue(8'h00, 16'h0000, 16'h0000, 1'b0, 16'h9999, 16'h0900);  // R1 other classes
        issue(8'h45, 16'h0001, 16'h0002, 1'b0, 16'h9999, 16'h0900);
        issue(8'hC0, 16'h0000, 16'h0000, 1'b1, 16'h9999, 16'hFFFF);  // R8 wrap
        issue(8'h86, 16'h0002, 16'h0001, 1'b0, 16'hFFFE, 16'hFFFE);
        idle_cycle();
        idle_cycle();

        // Constrained random mix
        for (int i = 0; i < 800; i++) begin
            logic [7:0] op;
            if ($urandom_range(1, 0) == 1) op = 8'h80 | 8'($urandom_range(7, 0));
            else                           op = 8'($urandom);
            issue(op,
                  ($urandom_range(3, 0) == 0) ? 16'($urandom_range(2, 0)) : 16'($urandom),
                  ($urandom_range(3, 0) == 0) ? 16'($urandom_range(2, 0)) : 16'($urandom),
                  1'($urandom), 16'($urandom), 16'($urandom));
            if ($urandom_range(7, 0) == 0) idle_cycle();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule